// File: doc/BRIEF.md
# DDS Control Word Loader

This block is the register-loading front end of a direct digital synthesizer. Software or a controller assembles a 40-bit control word in an input register. It does this either one byte at a time over an 8-bit bus or one bit at a time on data bit 0. Each write is marked by a rising edge on a word strobe. A rising edge on an update strobe then commits the assembled word to the active registers, which hold the frequency tuning word, a 5-bit phase offset, a power-down flag and a reference-multiplier enable.

The interface comes out of reset in byte-wide mode. A first byte whose low three bits are `011`, committed by an update edge, moves it permanently into bit-serial mode. A word whose control bit (bit 33) is set is rejected. A small phase accumulator advances by the tuning word on every system clock and stops while power-down is set, so that the effects of reset and update can be seen at the ports.

All strobes are sampled on the system clock. An edge is detected as low in one cycle and high in the next. The active registers change on the same clock edge at which the update strobe is first seen high.

Top module: `dds_word_loader`

## Requirements
- R1: While `rst` is high, the tuning word, phase offset, power-down flag, multiplier enable and phase accumulator are all cleared to zero, and the interface returns to byte-wide mode (`serial_mode` = 0).
- R2: Reset does not clear the 40-bit input register. An update edge after reset, with no writes in between, commits the word assembled before reset.
- R3: In byte-wide mode, successive word-strobe rising edges store `din` into bits [39:32], [31:24], [23:16], [15:8] and [7:0] in that order. An update edge returns the byte pointer to the first slot.
- R4: In byte-wide mode, word-strobe edges after the fifth byte and before the next update edge leave the input register unchanged.
- R5: On an update edge with word bit 33 = 0, the active registers take tuning word = bits [31:0], multiplier enable = bit 32, power-down = bit 34 and phase offset = bits [39:35].
- R6: In byte-wide mode, an update edge with word bits [34:32] = `011` sets `serial_mode` and leaves the active registers unchanged. `serial_mode` then stays set until reset.
- R7: In serial mode, each word-strobe rising edge shifts `din[0]` into the input register least significant bit first. After 40 edges, the first bit sent is bit 0 and the last bit sent is bit 39.
- R8: An update edge whose word has bit 33 = 1, other than the R6 case, leaves every active register unchanged.
- R9: On every clock with power-down clear, the phase accumulator adds the tuning word modulo 2^32. While power-down is set, the accumulator holds its value.
- R10: Committing a word with bit 34 = 0 clears power-down, and the accumulator resumes advancing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, synchronous |
| wr_strobe | input | 1 | Word strobe; a rising edge writes a byte or a bit |
| upd_strobe | input | 1 | Update strobe; a rising edge commits the input register |
| din | input | 8 | Data byte; bit 0 carries serial data |
| ftw | output | 32 | Active frequency tuning word |
| phase_off | output | 5 | Active phase offset |
| pwr_down | output | 1 | Active power-down flag |
| ref_mult_en | output | 1 | Active reference-multiplier enable |
| serial_mode | output | 1 | 1 when the interface is in bit-serial mode |
| phase_acc | output | 32 | Phase accumulator value |

## Verification
The bench builds the block with its default parameters: a 32-bit tuning word, a 5-bit phase offset and an 8-bit bus, which give the 40-bit word and its five-byte sequence. Tuning words near 2^32 make the accumulator wrap within a few clocks, which exercises the modulo sum. The full 40-bit serial shift stays within a short run. The one-way mode switch is exercised only after all of the byte-wide cases have been covered.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;
    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } load_mode_e;
endpackage

// File: rtl/dds_strobe_edge.sv
module dds_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/dds_input_reg.sv
module dds_input_reg
    import dds_loader_pkg::*;
#(
    parameter int FTW_W  = 32,
    parameter int PH_W   = 5,
    parameter int BYTE_W = 8,
    localparam int WORD_W = FTW_W + 3 + PH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  load_mode_e        mode,
    input  logic              wr_rise,
    input  logic              upd_rise,
    input  logic [BYTE_W-1:0] din,
    output logic [WORD_W-1:0] word
);
    localparam int NUM_BYTES = WORD_W / BYTE_W;
    localparam int PTR_W     = $clog2(NUM_BYTES + 1);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [WORD_W-1:0] word;
    } ld_t;

    ld_t ld_d, ld_q;

    always_comb begin
        ld_d = ld_q;
        if (upd_rise) begin
            ld_d.ptr = '0;
        end else if (wr_rise) begin
            if (mode == MODE_SER) begin
                ld_d.word = {din[0], ld_q.word[WORD_W-1:1]};
            end else if (ld_q.ptr < PTR_W'(NUM_BYTES)) begin
                for (int k = 0; k < NUM_BYTES; k++) begin
                    if (ld_q.ptr == PTR_W'(k))
                        ld_d.word[WORD_W-1-k*BYTE_W -: BYTE_W] = din;
                end
                ld_d.ptr = ld_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ld_q.ptr <= '0;
        else     ld_q     <= ld_d;
    end

    assign word = ld_q.word;

    // R4
    ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ld_q.ptr <= PTR_W'(NUM_BYTES));

    // R3
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        upd_rise |=> ld_q.ptr == '0);

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PAR && ld_q.ptr == PTR_W'(NUM_BYTES) && !upd_rise) |=> $stable(ld_q.word));
endmodule

// File: rtl/dds_ctrl_regs.sv
module dds_ctrl_regs
    import dds_loader_pkg::*;
#(
    parameter int FTW_W = 32,
    parameter int PH_W  = 5,
    localparam int WORD_W = FTW_W + 3 + PH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_rise,
    input  logic [WORD_W-1:0] word,
    output load_mode_e        mode,
    output logic [FTW_W-1:0]  ftw,
    output logic [PH_W-1:0]   phase_off,
    output logic              pwr_down,
    output logic              mult_en
);
    localparam int MULT_BIT = FTW_W;
    localparam int CTL_BIT  = FTW_W + 1;
    localparam int PD_BIT   = FTW_W + 2;

    typedef struct packed {
        load_mode_e       mode;
        logic [FTW_W-1:0] ftw;
        logic [PH_W-1:0]  ph;
        logic             pd;
        logic             mult;
    } act_t;

    act_t act_d, act_q;
    logic ser_q;

    always_comb begin
        act_d = act_q;
        if (upd_rise) begin
            if (!word[CTL_BIT]) begin
                act_d.ftw  = word[FTW_W-1:0];
                act_d.mult = word[MULT_BIT];
                act_d.pd   = word[PD_BIT];
                act_d.ph   = word[WORD_W-1:PD_BIT+1];
            end else if (act_q.mode == MODE_PAR && word[PD_BIT:MULT_BIT] == 3'b011) begin
                act_d.mode = MODE_SER;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) act_q <= '{mode: MODE_PAR, default: '0};
        else     act_q <= act_d;
    end

    assign mode      = act_q.mode;
    assign ftw       = act_q.ftw;
    assign phase_off = act_q.ph;
    assign pwr_down  = act_q.pd;
    assign mult_en   = act_q.mult;
    assign ser_q     = (act_q.mode == MODE_SER);

    // R8
    bad_word_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_rise && word[CTL_BIT]) |=> ($stable(act_q.ftw) && $stable(act_q.pd) &&
                                         $stable(act_q.ph) && $stable(act_q.mult)));

    // R6
    mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ser_q |=> ser_q);

    // R6
    mode_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_q) |-> $past(upd_rise));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc
);
    logic [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = freeze ? acc_q : acc_q + step;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign acc = acc_q;

    // R9
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(acc_q));
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
    import dds_loader_pkg::*;
#(
    parameter int FTW_W  = 32,
    parameter int PH_W   = 5,
    parameter int BYTE_W = 8,
    localparam int WORD_W = FTW_W + 3 + PH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_strobe,
    input  logic              upd_strobe,
    input  logic [BYTE_W-1:0] din,
    output logic [FTW_W-1:0]  ftw,
    output logic [PH_W-1:0]   phase_off,
    output logic              pwr_down,
    output logic              ref_mult_en,
    output logic              serial_mode,
    output logic [FTW_W-1:0]  phase_acc
);
    logic              wr_rise, upd_rise;
    logic [WORD_W-1:0] word;
    load_mode_e        mode;

    dds_strobe_edge u_wr_edge  (.clk(clk), .rst(rst), .lvl(wr_strobe),  .rise(wr_rise));
    dds_strobe_edge u_upd_edge (.clk(clk), .rst(rst), .lvl(upd_strobe), .rise(upd_rise));

    dds_input_reg #(.FTW_W(FTW_W), .PH_W(PH_W), .BYTE_W(BYTE_W)) u_in (
        .clk(clk), .rst(rst), .mode(mode), .wr_rise(wr_rise),
        .upd_rise(upd_rise), .din(din), .word(word)
    );

    dds_ctrl_regs #(.FTW_W(FTW_W), .PH_W(PH_W)) u_ctrl (
        .clk(clk), .rst(rst), .upd_rise(upd_rise), .word(word), .mode(mode),
        .ftw(ftw), .phase_off(phase_off), .pwr_down(pwr_down), .mult_en(ref_mult_en)
    );

    dds_phase_acc #(.ACC_W(FTW_W)) u_acc (
        .clk(clk), .rst(rst), .freeze(pwr_down), .step(ftw), .acc(phase_acc)
    );

    assign serial_mode = (mode == MODE_SER);
endmodule

// File: tb/dds_word_loader_test.sv
module dds_word_loader_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_strobe = 1'b0;
    logic upd_strobe = 1'b0;
    logic [7:0] din = 8'h00;
    logic [31:0] ftw, phase_acc;
    logic [4:0] phase_off;
    logic pwr_down, ref_mult_en, serial_mode;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dds_word_loader uut (
        .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .upd_strobe(upd_strobe), .din(din),
        .ftw(ftw), .phase_off(phase_off), .pwr_down(pwr_down), .ref_mult_en(ref_mult_en),
        .serial_mode(serial_mode), .phase_acc(phase_acc)
    );

    // behavioural reference model
    logic [39:0] m_word = '0;
    logic [31:0] m_ftw = '0, m_acc = '0;
    logic [4:0]  m_ph = '0;
    logic        m_pd = 0, m_mult = 0, m_ser = 0, m_wprev = 0, m_fprev = 0;
    int          m_ptr = 0;
    bit          m_valid = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ftw = '0; m_acc = '0; m_ph = '0; m_pd = 0; m_mult = 0; m_ser = 0;
            m_ptr = 0; m_wprev = 0; m_fprev = 0; m_valid = 1;
        end else begin
            if (!m_pd) m_acc = m_acc + m_ftw;
            if (upd_strobe && !m_fprev) begin
                if (m_word[33] == 1'b0) begin
                    m_ftw = m_word[31:0]; m_mult = m_word[32];
                    m_pd = m_word[34]; m_ph = m_word[39:35];
                end else if (!m_ser && m_word[34:32] == 3'b011) begin
                    m_ser = 1;
                end
                m_ptr = 0;
            end else if (wr_strobe && !m_wprev) begin
                if (m_ser) m_word = {din[0], m_word[39:1]};
                else if (m_ptr < 5) begin
                    m_word[39-8*m_ptr -: 8] = din;
                    m_ptr++;
                end
            end
            m_wprev = wr_strobe; m_fprev = upd_strobe;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (m_valid) begin
            chk("R5 ftw",         64'(ftw),         64'(m_ftw));
            chk("R5 phase_off",   64'(phase_off),   64'(m_ph));
            chk("R5 ref_mult_en", 64'(ref_mult_en), 64'(m_mult));
            chk("R10 pwr_down",   64'(pwr_down),    64'(m_pd));
            chk("R6 serial_mode", 64'(serial_mode), 64'(m_ser));
            chk("R9 phase_acc",   64'(phase_acc),   64'(m_acc));
        end
    end

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); din = b; wr_strobe = 1'b1;
        @(negedge clk); wr_strobe = 1'b0;
    endtask

    task automatic wr_word(input logic [39:0] w);
        for (int k = 0; k < 5; k++) wr_byte(w[39-8*k -: 8]);
    endtask

    task automatic shift_word(input logic [39:0] w);
        for (int i = 0; i < 40; i++) wr_byte({7'b0, w[i]});
    endtask

    task automatic commit();
        @(negedge clk); upd_strobe = 1'b1;
        @(negedge clk); upd_strobe = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (6) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [31:0] held;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 ftw", 64'(ftw), 0); chk("R1 acc", 64'(phase_acc), 0);
        chk("R1 pd", 64'(pwr_down), 0); chk("R1 serial", 64'(serial_mode), 0);

        // R3 R5 byte load
        wr_word(40'h00_1234_5678); commit();
        chk("R3 ftw byte order", 64'(ftw), 64'h1234_5678);
        repeat (4) @(negedge clk);

        // R5 field positions
        wr_word(40'hA9_F000_0001); commit();
        chk("R5 phase", 64'(phase_off), 21); chk("R5 mult", 64'(ref_mult_en), 1);
        chk("R5 ftw", 64'(ftw), 64'hF000_0001);
        repeat (5) @(negedge clk);

        // R4 extra byte ignored
        wr_word(40'h00_0000_0011); wr_byte(8'hFF); commit();
        chk("R4 extra byte", 64'(ftw), 64'h11);

        // R8 control bit set in byte mode
        wr_word(40'h02_DEAD_BEEF); commit();
        chk("R8 rejected", 64'(ftw), 64'h11);

        // R9 power-down freezes accumulator
        wr_word(40'h04_0100_0000); commit();
        chk("R9 pd set", 64'(pwr_down), 1);
        held = phase_acc;
        repeat (5) @(negedge clk);
        chk("R9 frozen", 64'(phase_acc), 64'(held));

        // R10 resume
        wr_word(40'h00_0100_0000); commit();
        chk("R10 pd clear", 64'(pwr_down), 0);
        held = phase_acc;
        @(negedge clk);
        chk("R10 resumed", 64'(phase_acc), 64'(held + 32'h0100_0000));

        // R2 input register survives reset
        wr_word(40'h00_CAFE_0001);
        do_reset();
        chk("R1 ftw after reset", 64'(ftw), 0);
        commit();
        chk("R2 kept word", 64'(ftw), 64'hCAFE_0001);

        // R6 enter serial mode
        wr_byte(8'h03); commit();
        chk("R6 serial", 64'(serial_mode), 1);
        chk("R6 ftw kept", 64'(ftw), 64'hCAFE_0001);

        // R7 serial word, LSB first
        shift_word(40'h18_8765_4321); commit();
        chk("R7 ftw", 64'(ftw), 64'h8765_4321);
        chk("R7 phase", 64'(phase_off), 3);

        // R8 invalid serial word
        shift_word(40'h02_0000_0001); commit();
        chk("R8 serial rejected", 64'(ftw), 64'h8765_4321);
        chk("R6 still serial", 64'(serial_mode), 1);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule